// File: doc/BRIEF.md
# USB Host Command and Status Register

This block is the command/status word of a USB host controller. Software sets command bits by writing ones over a register bus. A zero in any write position has no effect. Software can read the whole word at any time. Hardware clears the bits that need clearing, and hardware alone advances a small event counter.

At every end-of-frame strobe the block checks whether the periodic schedule has finished. If it has not, that frame is a scheduling overrun. An overrun advances a wrapping 2-bit counter and sends a one-cycle request to a separate interrupt-status register. The counter advances on every overrun, whatever the state of that interrupt flag, so software can see repeated trouble.

Bit 3 carries an ownership-change request. Setting it sends a one-cycle request for the ownership-change interrupt flag. A completion handshake clears it again. Bits 2..0 are generic set-only command bits, each cleared by its own external clear line.

Top module: `usb_hc_cmdstat`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), rd_data is 0 and both pulse outputs are 0.
- R2: A write with wr_en high sets every bit of bits 3..0 whose wr_data bit is 1. Bits written with 0 keep their value.
- R3: A clock edge with eof_stb high and list_done low is an overrun. The counter in rd_data[17:16] then reads one more after that edge. An eof_stb with list_done high leaves it unchanged.
- R4: The counter wraps from 3 to 0 on the next overrun.
- R5: ovr_irq_set is high for exactly the one cycle after each overrun edge and low otherwise. Back-to-back overruns give one high cycle each, and the counter still advances each time.
- R6: Writes to bits 17..16 have no effect. An overrun in the same cycle as a write still advances the counter.
- R7: own_irq_set is high for one cycle, in the first cycle that bit 3 reads 1. Writing 1 to bit 3 while it is already set gives no further pulse.
- R8: own_done high clears bit 3 at that edge, and the bit stays 0 until the next write of 1. A write of 1 to bit 3 in the same cycle as own_done leaves the bit set.
- R9: low_clr[i] high clears bit i of bits 2..0 at that edge. A write of 1 to the same bit in the same cycle wins, and the bit stays set.
- R10: Bits 31..18 and 15..4 always read 0, whatever is written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Write data, ones set bits |
| rd_data | output | 32 | Current register value |
| eof_stb | input | 1 | End-of-frame strobe |
| list_done | input | 1 | Periodic list finished this frame |
| own_done | input | 1 | Ownership change completed |
| low_clr | input | 3 | Per-bit clear for bits 2..0 |
| low_cmd | output | 3 | Current bits 2..0 |
| ovr_irq_set | output | 1 | Pulse that sets the overrun interrupt flag |
| own_irq_set | output | 1 | Pulse that sets the ownership-change interrupt flag |

## Verification
Every piece of state is visible in rd_data one clock after the edge that changed it. A wrong counter step, a missed wrap or an ignored write protection therefore shows up in the next read. A lost or repeated interrupt request shows on the pulse outputs in the cycle right after the cause. Such an error cannot be hidden by later traffic, because the bench samples each pulse in its own cycle. It also drives the same-cycle collisions between write, clear and overrun on purpose.

// File: rtl/usbhc_cmd_pkg.sv
// Package: field positions and widths of the command/status word.
// Assumes a 32-bit register with the counter and request bits at fixed places.
package usbhc_cmd_pkg;
    localparam int REG_W   = 32;
    localparam int CNT_W   = 2;
    localparam int CNT_LSB = 16;
    localparam int OWN_BIT = 3;
    localparam int LOW_W   = 3;
endpackage

// File: rtl/usbhc_ovr_counter.sv
// Overrun detector and wrapping counter.
// Assumes eof_stb is a single-cycle strobe; list_done is valid whenever eof_stb is high.
module usbhc_ovr_counter #(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             eof_stb,
    input  logic             list_done,
    output logic [CNT_W-1:0] cnt,
    output logic             ovr_pulse
);
    logic overrun;

    // Detect an unfinished schedule at end of frame.
    always_comb overrun = eof_stb && !list_done;

    // Advance the counter (natural wrap) and register the interrupt request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt       <= '0;
            ovr_pulse <= 1'b0;
        end else begin
            if (overrun) cnt <= cnt + 1'b1;
            ovr_pulse <= overrun;
        end
    end

    a_r3_count_step: assert property (@(posedge clk) disable iff (!rst_n)
        (eof_stb && !list_done) |=> (cnt == CNT_W'($past(cnt) + 1'b1)));
    a_r6_count_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !(eof_stb && !list_done) |=> $stable(cnt));
    a_r5_pulse_cause: assert property (@(posedge clk) disable iff (!rst_n)
        ovr_pulse |-> $past(eof_stb && !list_done));
endmodule

// File: rtl/usbhc_own_req.sv
// Ownership-change request bit with a rising-edge interrupt request.
// Assumes own_done is a handshake from the controller; a new write request wins over it.
module usbhc_own_req (
    input  logic clk,
    input  logic rst_n,
    input  logic set_req,
    input  logic own_done,
    output logic own_q,
    output logic own_pulse
);
    logic own_d;

    // Next request state: a write sets it, completion clears it, setting wins.
    always_comb begin
        own_d = own_q;
        if (own_done) own_d = 1'b0;
        if (set_req)  own_d = 1'b1;
    end

    // Hold the bit and pulse once when it turns on.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            own_q     <= 1'b0;
            own_pulse <= 1'b0;
        end else begin
            own_q     <= own_d;
            own_pulse <= own_d && !own_q;
        end
    end

    a_r7_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        own_pulse |-> (own_q && !$past(own_q)));
    a_r8_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (own_done && !set_req) |=> !own_q);
endmodule

// File: rtl/usbhc_low_bits.sv
// Generic set-only command bits with per-bit external clear.
// Assumes a write of one and a clear of the same bit in one cycle resolve to set.
module usbhc_low_bits #(
    parameter int LOW_W = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LOW_W-1:0] set_mask,
    input  logic [LOW_W-1:0] clr_mask,
    output logic [LOW_W-1:0] bits_q
);
    for (genvar i = 0; i < LOW_W; i++) begin : g_bit
        // Per-bit storage: set has priority over clear.
        always_ff @(posedge clk) begin
            if (!rst_n)           bits_q[i] <= 1'b0;
            else if (set_mask[i]) bits_q[i] <= 1'b1;
            else if (clr_mask[i]) bits_q[i] <= 1'b0;
        end

        a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_mask[i] && !set_mask[i]) |=> !bits_q[i]);
        a_r2_set: assert property (@(posedge clk) disable iff (!rst_n)
            set_mask[i] |=> bits_q[i]);
    end
endmodule

// File: rtl/usb_hc_cmdstat.sv
// Top: USB host command/status word, write-one-to-set, read anytime.
// Assumes rd_data is sampled by the bus directly; reserved fields are tied to zero.
module usb_hc_cmdstat
    import usbhc_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [REG_W-1:0]  wr_data,
    output logic [REG_W-1:0]  rd_data,
    input  logic              eof_stb,
    input  logic              list_done,
    input  logic              own_done,
    input  logic [LOW_W-1:0]  low_clr,
    output logic [LOW_W-1:0]  low_cmd,
    output logic              ovr_irq_set,
    output logic              own_irq_set
);
    logic [CNT_W-1:0] cnt;
    logic             own_q;
    logic [LOW_W-1:0] low_set;

    // Decode write-one-to-set masks for the low command bits.
    always_comb low_set = wr_en ? wr_data[LOW_W-1:0] : '0;

    usbhc_ovr_counter #(.CNT_W(CNT_W)) u_ovr (
        .clk(clk), .rst_n(rst_n), .eof_stb(eof_stb), .list_done(list_done),
        .cnt(cnt), .ovr_pulse(ovr_irq_set));

    usbhc_own_req u_own (
        .clk(clk), .rst_n(rst_n), .set_req(wr_en && wr_data[OWN_BIT]),
        .own_done(own_done), .own_q(own_q), .own_pulse(own_irq_set));

    usbhc_low_bits #(.LOW_W(LOW_W)) u_low (
        .clk(clk), .rst_n(rst_n), .set_mask(low_set), .clr_mask(low_clr),
        .bits_q(low_cmd));

    // Assemble the read word; unlisted fields read zero.
    always_comb begin
        rd_data = '0;
        rd_data[CNT_LSB +: CNT_W] = cnt;
        rd_data[OWN_BIT]          = own_q;
        rd_data[LOW_W-1:0]        = low_cmd;
    end

    a_r1_reset_clean: assert property (@(posedge clk)
        !rst_n |=> (rd_data == '0 && !ovr_irq_set && !own_irq_set));
endmodule

// File: tb/usb_hc_cmdstat_tb.sv
module usb_hc_cmdstat_tb;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        wr_en = 0;
    logic [31:0] wr_data = 0;
    logic [31:0] rd_data;
    logic        eof_stb = 0, list_done = 0, own_done = 0;
    logic [2:0]  low_clr = 0, low_cmd;
    logic        ovr_irq_set, own_irq_set;
    int checks = 0, errors = 0;

    always #10 clk = ~clk;

    usb_hc_cmdstat u_dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .rd_data(rd_data), .eof_stb(eof_stb), .list_done(list_done), .own_done(own_done),
        .low_clr(low_clr), .low_cmd(low_cmd), .ovr_irq_set(ovr_irq_set),
        .own_irq_set(own_irq_set));

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk); #1;
    endtask

    task automatic idle();
        wr_en = 0; wr_data = 0; eof_stb = 0; list_done = 0; own_done = 0; low_clr = 0;
    endtask

    task automatic do_reset();
        idle(); rst_n = 0; tick(); tick(); rst_n = 1;
        chk("R1 rd_data", rd_data, 0);
        chk("R1 pulses", {30'b0, ovr_irq_set, own_irq_set}, 0);
    endtask

    task automatic t_write_set();   // R2, R10
        wr_en = 1; wr_data = 32'h0000_0005; tick(); idle();
        chk("R2 set 0,2", rd_data, 32'h5);
        wr_en = 1; wr_data = 32'h0000_0000; tick(); idle();
        chk("R2 zero keeps", rd_data, 32'h5);
        wr_en = 1; wr_data = 32'hFFFC_FFF0; tick(); idle();
        chk("R10 reserved", rd_data, 32'h5);
        chk("R6 counter write", rd_data[17:16], 0);
    endtask

    task automatic overrun(input logic done);
        eof_stb = 1; list_done = done; tick(); idle();
    endtask

    task automatic t_overrun();     // R3 R4 R5
        overrun(1);
        chk("R3 done no count", rd_data[17:16], 0);
        chk("R5 no pulse", ovr_irq_set, 0);
        overrun(0);
        chk("R3 count 1", rd_data[17:16], 1);
        chk("R5 pulse", ovr_irq_set, 1);
        tick();
        chk("R5 pulse ends", ovr_irq_set, 0);
        eof_stb = 1; list_done = 0; tick();
        chk("R5 b2b pulse a", ovr_irq_set, 1);
        chk("R5 count 2", rd_data[17:16], 2);
        tick(); idle();
        chk("R5 b2b pulse b", ovr_irq_set, 1);
        chk("R5 count 3", rd_data[17:16], 3);
        overrun(0);
        chk("R4 wrap", rd_data[17:16], 0);
    endtask

    task automatic t_write_overrun(); // R6
        wr_en = 1; wr_data = 32'h0003_0000; eof_stb = 1; list_done = 0; tick(); idle();
        chk("R6 same cycle count", rd_data[17:16], 1);
        wr_en = 1; wr_data = 32'h0000_0000; tick(); idle();
        chk("R6 write no effect", rd_data[17:16], 1);
    endtask

    task automatic t_own();         // R7 R8
        wr_en = 1; wr_data = 32'h8; tick(); idle();
        chk("R7 bit set", rd_data[3], 1);
        chk("R7 pulse", own_irq_set, 1);
        tick();
        chk("R7 pulse ends", own_irq_set, 0);
        wr_en = 1; wr_data = 32'h8; tick(); idle();
        chk("R7 no repulse", own_irq_set, 0);
        own_done = 1; wr_en = 1; wr_data = 32'h8; tick(); idle();
        chk("R8 write wins", rd_data[3], 1);
        own_done = 1; tick(); idle();
        chk("R8 cleared", rd_data[3], 0);
        tick();
        chk("R8 stays clear", rd_data[3], 0);
        wr_en = 1; wr_data = 32'h8; tick(); idle();
        chk("R7 pulse again", own_irq_set, 1);
    endtask

    task automatic t_low();         // R9
        wr_en = 1; wr_data = 32'h7; tick(); idle();
        low_clr = 3'b010; tick(); idle();
        chk("R9 clear bit1", low_cmd, 3'b101);
        low_clr = 3'b101; wr_en = 1; wr_data = 32'h1; tick(); idle();
        chk("R9 set wins", low_cmd, 3'b001);
        chk("R9 rd view", rd_data[2:0], 3'b001);
    endtask

    initial begin
        fork
            begin
                do_reset();
                t_write_set();
                t_overrun();
                t_write_overrun();
                t_own();
                t_low();
                do_reset();
            end
            begin
                repeat (5000) @(posedge clk);
                errors++; checks++;
                $display("FAIL watchdog actual=timeout expected=done");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule